// File: doc/BRIEF.md
# Multichannel Character Service Scheduler

This block decides, cycle by cycle, which of eight serial channels gets attention from the character-processing side of a multichannel serial controller. Each channel has a receive holding register and a transmit holding register. Each register has a full/empty flag. The scheduler runs a fixed two-level rotation. Short inner slots visit the channels in turn and move one character per slot. After every eighth inner slot, one outer slot does housekeeping for a single channel. Housekeeping means taking a host command, taking a timer tick, and posting service requests into an eight-entry queue.

The controller is built on two states, `SL_INNER` and `SL_OUTER`. It has three transitions:
- `SL_INNER` to `SL_INNER`: the slot is stalled, or fewer than eight inner slots have completed.
- `SL_INNER` to `SL_OUTER`: the eighth inner slot completes.
- `SL_OUTER` to `SL_INNER`: this always happens after one cycle.

During an inner slot, receive always wins over transmit. A move is requested as a strobe plus a channel index. The move is held until the character side raises `mv_ready`. A service request stays marked as outstanding from the cycle it is posted until the host acknowledges it at the head of the queue. While a request is outstanding, an identical request is never posted.

Top module: `chan_sched`

## Requirements
- R1: After a synchronous active-high reset, the block is in an inner slot, both channel pointers are 0, the queue is empty (`q_valid` low) and no request is marked outstanding.
- R2: Exactly eight completed inner slots are followed by exactly one outer slot of one cycle (`in_outer` high), and the pattern repeats.
- R3: `move_ch` steps 0,1,…,7,0 by one per completed inner slot. `oslot_ch` steps the same way by one per outer slot.
- R4: In an inner slot, if `rx_full[move_ch]` is set, `move_rx` is high and `move_tx` is low.
- R5: `move_tx` is high only in an inner slot where `rx_full[move_ch]` is clear and `tx_empty[move_ch]` is set.
- R6: While `move_rx` or `move_tx` is high and `mv_ready` is low, the slot does not complete: `move_ch`, the slot count and the state hold.
- R7: An inner slot that needs no move completes in a single cycle with both move strobes low.
- R8: In the outer slot, `cmd_take` equals `cmd_pend[oslot_ch]` and `tick_take` equals `tick_pend[oslot_ch]`. Both are low in inner slots, and no move strobe is raised during the outer slot.
- R9: An outer slot posts at most one request (`post_req`) for channel `oslot_ch`. The type code is 0 for receive FIFO full (`rxq_full`), 1 for transmit FIFO empty (`txq_empty`) and 2 for modem change (`mdm_chg`). The lowest code whose condition holds and is not outstanding is chosen.
- R10: A (channel, type) pair is not posted again while an identical entry is still unacknowledged.
- R11: When the queue holds eight entries, nothing is posted. The condition is retried at that channel's next outer slot.
- R12: The queue is first-in first-out. The head appears on `q_ch`/`q_type` with `q_valid`. `q_ack` with `q_valid` removes the head and clears its outstanding mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_full | input | 8 | Per-channel receive holding register full |
| tx_empty | input | 8 | Per-channel transmit holding register empty |
| mv_ready | input | 1 | Character side accepts the requested move |
| move_rx | output | 1 | Move received character of `move_ch` |
| move_tx | output | 1 | Move transmit character into `move_ch` |
| move_ch | output | 3 | Inner-slot channel pointer |
| in_outer | output | 1 | Current cycle is the outer slot |
| oslot_ch | output | 3 | Outer-slot channel pointer |
| cmd_pend | input | 8 | Per-channel host command signalled |
| cmd_take | output | 1 | Command of `oslot_ch` applied this cycle |
| tick_pend | input | 8 | Per-channel timer event pending |
| tick_take | output | 1 | Timer event of `oslot_ch` taken this cycle |
| rxq_full | input | 8 | Per-channel receive FIFO full condition |
| txq_empty | input | 8 | Per-channel transmit FIFO empty condition |
| mdm_chg | input | 8 | Per-channel modem signal change condition |
| post_req | output | 1 | Request pushed into the queue this cycle |
| post_ch | output | 3 | Channel of the pushed request |
| post_type | output | 2 | Type code of the pushed request (0 rx, 1 tx, 2 modem) |
| q_valid | output | 1 | Queue head is valid |
| q_ch | output | 3 | Channel of queue head |
| q_type | output | 2 | Type code of queue head |
| q_ack | input | 1 | Host acknowledges and removes the queue head |

## Verification
Several input patterns are applied.
- Sparse flags with an always-ready sink show the basic rotation and the one-cycle empty slots.
- Dense receive and transmit flags with a sporadic `mv_ready` separate receive priority from transmit and show that stalls hold the rotation.
- A transmit-only phase shows that the transmit path is taken when no receive character waits.
- Heavy service conditions with no host acknowledge fill the queue. This exposes duplicate suppression and the full-queue retry.
- A drain phase and a mixed phase then show FIFO order and the clearing of outstanding marks.

// File: rtl/chan_sched_pkg.sv
package chan_sched_pkg;

    typedef enum logic {
        SL_INNER = 1'b0,
        SL_OUTER = 1'b1
    } slot_t;

    typedef enum logic [1:0] {
        REQ_RX  = 2'd0,
        REQ_TX  = 2'd1,
        REQ_MDM = 2'd2
    } req_t;

    localparam int unsigned NUM_REQ_TYPES = 3;

endpackage

// File: rtl/sched_fsm.sv
module sched_fsm
    import chan_sched_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned RUN = 8,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned CW  = (RUN > 1) ? $clog2(RUN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slot_done,
    output slot_t          state,
    output logic [CHW-1:0] iptr,
    output logic [CHW-1:0] optr
);

    slot_t          state_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic [CHW-1:0] iptr_n, optr_n;

    function automatic logic [CHW-1:0] wrap_inc(input logic [CHW-1:0] p);
        return (p == CHW'(NCH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SL_INNER;
            cnt   <= '0;
            iptr  <= '0;
            optr  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            iptr  <= iptr_n;
            optr  <= optr_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        iptr_n  = iptr;
        optr_n  = optr;
        unique case (state)
            SL_INNER: begin
                if (slot_done) begin
                    iptr_n = wrap_inc(iptr);
                    if (cnt == CW'(RUN - 1)) begin
                        cnt_n   = '0;
                        state_n = SL_OUTER;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            SL_OUTER: begin
                optr_n  = wrap_inc(optr);
                state_n = SL_INNER;
            end
            default: state_n = SL_INNER;
        endcase
    end

    assert_outer_single_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SL_OUTER) |=> (state == SL_INNER));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SL_INNER && !slot_done) |=> (state == SL_INNER && $stable(iptr)));

endmodule

// File: rtl/inner_arb.sv
module inner_arb #(
    parameter int unsigned NCH = 8,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    input  logic [CHW-1:0] ch,
    input  logic [NCH-1:0] rx_full,
    input  logic [NCH-1:0] tx_empty,
    input  logic           ready,
    output logic           move_rx,
    output logic           move_tx,
    output logic           done
);

    logic rx_w, tx_w;

    always_comb begin
        rx_w    = rx_full[ch];
        tx_w    = tx_empty[ch];
        move_rx = active && rx_w;
        move_tx = active && !rx_w && tx_w;
        done    = active && ((!move_rx && !move_tx) || ready);
    end

    assert_rx_over_tx_R4: assert property (@(posedge clk) disable iff (rst)
        (active && rx_full[ch]) |-> (move_rx && !move_tx));

    assert_idle_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !rx_full[ch] && !tx_empty[ch]) |-> done);

endmodule

// File: rtl/svc_post.sv
module svc_post
    import chan_sched_pkg::*;
#(
    parameter int unsigned NCH = 8,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           outer,
    input  logic [CHW-1:0] ch,
    input  logic [NCH-1:0] rxq_full,
    input  logic [NCH-1:0] txq_empty,
    input  logic [NCH-1:0] mdm_chg,
    input  logic           q_full,
    input  logic           ack,
    input  logic [CHW-1:0] ack_ch,
    input  logic [1:0]     ack_type,
    output logic           post,
    output logic [1:0]     post_type
);

    logic [NUM_REQ_TYPES-1:0] mark [NCH];
    logic [NUM_REQ_TYPES-1:0] cond, cand;
    logic                     any;

    always_comb begin
        cond = {mdm_chg[ch], txq_empty[ch], rxq_full[ch]};
        cand = cond & ~mark[ch];
        any  = |cand;
        if (cand[REQ_RX])       post_type = REQ_RX;
        else if (cand[REQ_TX])  post_type = REQ_TX;
        else                    post_type = REQ_MDM;
        post = outer && any && !q_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NCH); i++) mark[i] <= '0;
        end else begin
            if (ack)  mark[ack_ch][ack_type] <= 1'b0;
            if (post) mark[ch][post_type]    <= 1'b1;
        end
    end

    assert_post_in_outer_R9: assert property (@(posedge clk) disable iff (rst)
        post |-> outer);

    assert_no_dup_R10: assert property (@(posedge clk) disable iff (rst)
        post |=> mark[$past(ch)][$past(post_type)]);

endmodule

// File: rtl/req_fifo.sv
module req_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 5,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned NW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] head
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr, rd;
    logic [NW-1:0] count;
    logic          do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (count == NW'(DEPTH));
        valid  = (count != '0);
        head   = mem[rd];
        do_pop = pop && valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr    <= '0;
            rd    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wr] <= din;
                wr      <= nxt(wr);
            end
            if (do_pop) rd <= nxt(rd);
            count <= count + NW'(push) - NW'(do_pop);
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    assert_count_bound_R12: assert property (@(posedge clk) disable iff (rst)
        count <= NW'(DEPTH));

endmodule

// File: rtl/chan_sched.sv
module chan_sched
    import chan_sched_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned RUN    = 8,
    parameter int unsigned QDEPTH = 8,
    localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned EW    = CHW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] rx_full,
    input  logic [NCH-1:0] tx_empty,
    input  logic           mv_ready,
    output logic           move_rx,
    output logic           move_tx,
    output logic [CHW-1:0] move_ch,
    output logic           in_outer,
    output logic [CHW-1:0] oslot_ch,
    input  logic [NCH-1:0] cmd_pend,
    output logic           cmd_take,
    input  logic [NCH-1:0] tick_pend,
    output logic           tick_take,
    input  logic [NCH-1:0] rxq_full,
    input  logic [NCH-1:0] txq_empty,
    input  logic [NCH-1:0] mdm_chg,
    output logic           post_req,
    output logic [CHW-1:0] post_ch,
    output logic [1:0]     post_type,
    output logic           q_valid,
    output logic [CHW-1:0] q_ch,
    output logic [1:0]     q_type,
    input  logic           q_ack
);

    slot_t          state;
    logic           slot_done;
    logic           inner_act;
    logic           q_full;
    logic [EW-1:0]  q_head;

    sched_fsm #(.NCH(NCH), .RUN(RUN)) u_fsm (
        .clk(clk), .rst(rst), .slot_done(slot_done),
        .state(state), .iptr(move_ch), .optr(oslot_ch)
    );

    always_comb begin
        inner_act = (state == SL_INNER);
        in_outer  = (state == SL_OUTER);
        cmd_take  = in_outer && cmd_pend[oslot_ch];
        tick_take = in_outer && tick_pend[oslot_ch];
        post_ch   = oslot_ch;
        q_ch      = q_head[EW-1:2];
        q_type    = q_head[1:0];
    end

    inner_arb #(.NCH(NCH)) u_arb (
        .clk(clk), .rst(rst), .active(inner_act), .ch(move_ch),
        .rx_full(rx_full), .tx_empty(tx_empty), .ready(mv_ready),
        .move_rx(move_rx), .move_tx(move_tx), .done(slot_done)
    );

    svc_post #(.NCH(NCH)) u_post (
        .clk(clk), .rst(rst), .outer(in_outer), .ch(oslot_ch),
        .rxq_full(rxq_full), .txq_empty(txq_empty), .mdm_chg(mdm_chg),
        .q_full(q_full), .ack(q_ack && q_valid), .ack_ch(q_ch),
        .ack_type(q_type), .post(post_req), .post_type(post_type)
    );

    req_fifo #(.DEPTH(QDEPTH), .W(EW)) u_q (
        .clk(clk), .rst(rst), .push(post_req), .din({oslot_ch, post_type}),
        .pop(q_ack), .full(q_full), .valid(q_valid), .head(q_head)
    );

    assert_outer_no_move_R8: assert property (@(posedge clk) disable iff (rst)
        in_outer |-> (!move_rx && !move_tx));

endmodule

// File: tb/sim_chan_sched.sv
module sim_chan_sched;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_full = '0, tx_empty = '0, cmd_pend = '0, tick_pend = '0;
    logic [7:0] rxq_full = '0, txq_empty = '0, mdm_chg = '0;
    logic       mv_ready = 1'b0, q_ack = 1'b0;
    logic       move_rx, move_tx, in_outer, cmd_take, tick_take, post_req, q_valid;
    logic [2:0] move_ch, oslot_ch, post_ch, q_ch;
    logic [1:0] post_type, q_type;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int m_outer, m_cnt, m_i, m_o;
    int q_c[$];
    int q_t[$];
    bit mark[8][3];

    always #2 clk = ~clk;

    chan_sched u0 (
        .clk(clk), .rst(rst), .rx_full(rx_full), .tx_empty(tx_empty),
        .mv_ready(mv_ready), .move_rx(move_rx), .move_tx(move_tx),
        .move_ch(move_ch), .in_outer(in_outer), .oslot_ch(oslot_ch),
        .cmd_pend(cmd_pend), .cmd_take(cmd_take), .tick_pend(tick_pend),
        .tick_take(tick_take), .rxq_full(rxq_full), .txq_empty(txq_empty),
        .mdm_chg(mdm_chg), .post_req(post_req), .post_ch(post_ch),
        .post_type(post_type), .q_valid(q_valid), .q_ch(q_ch),
        .q_type(q_type), .q_ack(q_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] rvec(input int pct);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = ($urandom_range(0, 99) < pct);
        return v;
    endfunction

    task automatic model_reset();
        m_outer = 0; m_cnt = 0; m_i = 0; m_o = 0;
        q_c.delete(); q_t.delete();
        for (int c = 0; c < 8; c++)
            for (int t = 0; t < 3; t++) mark[c][t] = 0;
    endtask

    task automatic step_check();
        bit erx, etx, done, epost;
        int etype;
        bit [2:0] cond;
        erx = 0; etx = 0; epost = 0; etype = 0;
        if (!m_outer) begin
            erx = rx_full[m_i];
            etx = !erx && tx_empty[m_i];
        end else begin
            cond = {mdm_chg[m_o], txq_empty[m_o], rxq_full[m_o]};
            if (q_c.size() < 8) begin
                for (int t = 2; t >= 0; t--)
                    if (cond[t] && !mark[m_o][t]) begin epost = 1; etype = t; end
            end
        end
        chk("R2 in_outer", in_outer, m_outer);
        chk("R3 R6 R7 move_ch", move_ch, m_i);
        chk("R3 oslot_ch", oslot_ch, m_o);
        chk("R4 move_rx", move_rx, erx);
        chk("R5 move_tx", move_tx, etx);
        chk("R8 cmd_take", cmd_take, m_outer && cmd_pend[m_o]);
        chk("R8 tick_take", tick_take, m_outer && tick_pend[m_o]);
        chk("R9 R10 R11 post_req", post_req, epost);
        if (epost) begin
            chk("R9 post_ch", post_ch, m_o);
            chk("R9 post_type", post_type, etype);
        end
        chk("R12 q_valid", q_valid, q_c.size() > 0);
        if (q_c.size() > 0) begin
            chk("R12 q_ch", q_ch, q_c[0]);
            chk("R12 q_type", q_type, q_t[0]);
        end
        // model update for the coming edge
        if (q_ack && q_c.size() > 0) begin
            mark[q_c[0]][q_t[0]] = 0;
            void'(q_c.pop_front());
            void'(q_t.pop_front());
        end
        if (epost) begin
            q_c.push_back(m_o);
            q_t.push_back(etype);
            mark[m_o][etype] = 1;
        end
        if (!m_outer) begin
            done = (!erx && !etx) || mv_ready;
            if (done) begin
                m_i = (m_i + 1) % 8;
                if (m_cnt == 7) begin m_cnt = 0; m_outer = 1; end
                else m_cnt++;
            end
        end else begin
            m_o = (m_o + 1) % 8;
            m_outer = 0;
        end
    endtask

    task automatic phase(input int n, input int p_rx, input int p_tx, input int p_rdy,
                         input int p_cond, input int p_ack);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_full   = rvec(p_rx);
            tx_empty  = rvec(p_tx);
            cmd_pend  = rvec(30);
            tick_pend = rvec(30);
            rxq_full  = rvec(p_cond);
            txq_empty = rvec(p_cond);
            mdm_chg   = rvec(p_cond);
            mv_ready  = ($urandom_range(0, 99) < p_rdy);
            q_ack     = ($urandom_range(0, 99) < p_ack);
            #1;
            step_check();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state seen at the ports
        chk("R1 in_outer", in_outer, 0);
        chk("R1 move_ch", move_ch, 0);
        chk("R1 oslot_ch", oslot_ch, 0);
        chk("R1 q_valid", q_valid, 0);
        step_check();
        phase(600, 10, 10, 100, 5, 50);   // sparse traffic
        phase(600, 90, 90, 60, 10, 50);   // rx-heavy, stalls
        phase(600, 0, 80, 40, 10, 50);    // transmit only
        phase(100, 0, 0, 50, 0, 0);       // idle slots
        phase(800, 30, 30, 70, 80, 0);    // flood, no acknowledge
        phase(200, 30, 30, 70, 0, 100);   // drain
        phase(1000, 50, 50, 70, 40, 40);  // mixed
        // mid-run reset returns to R1 state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1 q_valid after reset", q_valid, 0);
        chk("R1 move_ch after reset", move_ch, 0);
        step_check();
        phase(300, 40, 40, 80, 30, 30);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule